// File: doc/BRIEF.md
# Debug Trigger Register Bank

This block holds the machine-mode control state for two address/data match triggers used by a hart's hardware breakpoint logic. Software reaches it through a small register port that selects one of four registers: the trigger selector, the control word of the selected trigger, the compare value of the selected trigger, and a third data slot that this bank does not implement. A register read returns its value in the same cycle. A write is stored at the next clock edge.

Every write to a control word is made legal before it is stored. The trigger kind field always holds the address/data match code and cannot be changed. The debug-only flag and all unsupported feature fields stay zero. The privilege and access enables are stored as written. A size code that is not supported is replaced by "any size". The stored control and compare values of both triggers leave the block on flat output buses, so a separate match unit can compare them against fetch and load/store addresses. The `XLEN` parameter selects the 32-bit or the 64-bit register layout. In the 64-bit layout the size code gains two upper bits.

An availability output tells software whether a given data slot exists for the currently selected trigger. Software can use it to probe how many triggers there are and which slots they use.

Top module: `dbg_trig_bank`

## Requirements
- R1: After reset the selector reads 0, each trigger's control word holds only the kind value 2 in its top four bits (every other bit zero), and each compare value is zero.
- R2: The selector (register code 0) stores the full XLEN-bit written value with no masking and reads it back unchanged.
- R3: Register code 1 (control) and code 2 (compare) access the trigger whose index equals the selector. The stored values of trigger k appear on `trig_ctrl_o[k*XLEN +: XLEN]` and `trig_addr_o[k*XLEN +: XLEN]`.
- R4: While the selector is 2 or more, reads of codes 1 and 2 return zero, and writes to them change neither trigger.
- R5: `avail_o` is 1 only when the selector is below 2 and `avail_idx_i` is 0 (control) or 1 (compare). Index 2 (third data slot) and index 3 always give 0.
- R6: The control word's top four bits always read 2, and the bit just below them (debug-only flag) always reads 0, whatever value is written.
- R7: Every control bit outside the kept fields reads 0. This covers the match, chain, action, timing, select and hit fields.
- R8: Load (bit 0), store (bit 1), execute (bit 2), user (bit 3), supervisor (bit 4) and machine (bit 6) enables are stored exactly as written.
- R9: The size code is {bits 22:21, bits 17:16} when XLEN is 64, and {2'b00, bits 17:16} when XLEN is 32. Codes 0, 1, 2, 3 and 5 are stored as written.
- R10: A written size code of any other value (4, 6 to 15) stores zero in both size fields.
- R11: The compare register stores the full XLEN-bit written value.
- R12: Register code 3 (third data slot) reads zero, and writes to it have no effect on any trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_sel_i | input | 2 | Register code: 0 selector, 1 control, 2 compare, 3 third slot |
| csr_we_i | input | 1 | Write strobe, taken at the rising edge |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data for `csr_sel_i`, combinational |
| avail_idx_i | input | 2 | Data slot index to query: 0 control, 1 compare, 2 third slot, 3 beyond |
| avail_o | output | 1 | Queried slot exists for the selected trigger |
| trig_ctrl_o | output | 2*XLEN | Stored control words, trigger 0 in the low half |
| trig_addr_o | output | 2*XLEN | Stored compare values, trigger 0 in the low half |

## Verification
A wrong selector would route the next control or compare access to the other trigger. This shows on the exported buses one cycle after the write, and on the read port in the same cycle as any read. A legalizer fault leaves an illegal size, a non-zero reserved bit or a changed kind field in storage. Such a fault is visible on `trig_ctrl_o` from the edge after the write onward, and it stays there until the next control write. Reads are combinational from state, so stale or misrouted storage is visible on the very first read.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

    typedef enum logic [1:0] {
        SEL_TSEL  = 2'd0,
        SEL_CTRL  = 2'd1,
        SEL_CMP   = 2'd2,
        SEL_THIRD = 2'd3
    } csr_sel_e;

    localparam logic [3:0] KIND_ADDR_MATCH = 4'd2;

    localparam int unsigned EN_LOAD  = 0;
    localparam int unsigned EN_STORE = 1;
    localparam int unsigned EN_EXEC  = 2;
    localparam int unsigned EN_USER  = 3;
    localparam int unsigned EN_SUPV  = 4;
    localparam int unsigned EN_MACH  = 6;
    localparam int unsigned SZ_LO    = 16;
    localparam int unsigned SZ_HI    = 21;

    // Supported size codes: any, 1, 2, 4 and 8 bytes
    function automatic logic size_code_ok(input logic [3:0] code);
        return (code <= 4'd3) || (code == 4'd5);
    endfunction

endpackage

// File: rtl/dbg_trig_legalize.sv
module dbg_trig_legalize
    import dbg_trig_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] raw_i,
    output logic [XLEN-1:0] legal_o
);

    localparam bit WIDE = (XLEN == 64);

    logic [1:0] sz_lo;
    logic [1:0] sz_hi;
    logic [3:0] sz_code;

    always_comb begin
        sz_lo   = raw_i[SZ_LO +: 2];
        sz_hi   = WIDE ? raw_i[SZ_HI +: 2] : 2'b00;
        sz_code = {sz_hi, sz_lo};

        legal_o = '0;
        legal_o[XLEN-1 -: 4] = KIND_ADDR_MATCH;
        legal_o[EN_LOAD]     = raw_i[EN_LOAD];
        legal_o[EN_STORE]    = raw_i[EN_STORE];
        legal_o[EN_EXEC]     = raw_i[EN_EXEC];
        legal_o[EN_USER]     = raw_i[EN_USER];
        legal_o[EN_SUPV]     = raw_i[EN_SUPV];
        legal_o[EN_MACH]     = raw_i[EN_MACH];
        if (size_code_ok(sz_code)) begin
            legal_o[SZ_LO +: 2] = sz_lo;
            if (WIDE) begin
                legal_o[SZ_HI +: 2] = sz_hi;
            end
        end
    end

endmodule

// File: rtl/dbg_trig_slot.sv
module dbg_trig_slot
    import dbg_trig_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            ctrl_we_i,
    input  logic            cmp_we_i,
    input  logic [XLEN-1:0] wdata_i,
    output logic [XLEN-1:0] ctrl_o,
    output logic [XLEN-1:0] cmp_o
);

    localparam bit WIDE = (XLEN == 64);
    localparam logic [XLEN-1:0] RST_CTRL = {KIND_ADDR_MATCH, {(XLEN-4){1'b0}}};
    localparam logic [XLEN-1:0] ENABLES  = XLEN'(7'b1011111);
    localparam logic [XLEN-1:0] SZ_MASK  = (XLEN'(2'b11) << SZ_LO)
                                         | (WIDE ? (XLEN'(2'b11) << SZ_HI) : '0);
    localparam logic [XLEN-1:0] KEEP     = ENABLES | SZ_MASK | (XLEN'(4'hF) << (XLEN-4));

    typedef struct packed {
        logic [XLEN-1:0] ctrl;
        logic [XLEN-1:0] cmp;
    } slot_t;

    slot_t slot_d, slot_q;
    logic [XLEN-1:0] legal_w;

    dbg_trig_legalize #(.XLEN(XLEN)) u_legal (
        .raw_i   (wdata_i),
        .legal_o (legal_w)
    );

    always_comb begin
        slot_d = slot_q;
        if (ctrl_we_i) slot_d.ctrl = legal_w;
        if (cmp_we_i)  slot_d.cmp  = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            slot_q.ctrl <= RST_CTRL;
            slot_q.cmp  <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign ctrl_o = slot_q.ctrl;
    assign cmp_o  = slot_q.cmp;

    // R6
    kind_pinned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_o[XLEN-1 -: 5] == {KIND_ADDR_MATCH, 1'b0});

    // R7
    reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_o & ~KEEP) == '0);

    // R10
    size_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        size_code_ok({WIDE ? ctrl_o[SZ_HI +: 2] : 2'b00, ctrl_o[SZ_LO +: 2]}));

    // R8
    enables_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_we_i |=> ((ctrl_o & ENABLES) == ($past(wdata_i) & ENABLES)));

    // R11
    cmp_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmp_we_i |=> (cmp_o == $past(wdata_i)));

endmodule

// File: rtl/dbg_trig_bank.sv
module dbg_trig_bank
    import dbg_trig_pkg::*;
#(
    parameter int unsigned XLEN     = 64,
    parameter int unsigned NUM_TRIG = 2
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [1:0]               csr_sel_i,
    input  logic                     csr_we_i,
    input  logic [XLEN-1:0]          csr_wdata_i,
    output logic [XLEN-1:0]          csr_rdata_o,
    input  logic [1:0]               avail_idx_i,
    output logic                     avail_o,
    output logic [NUM_TRIG*XLEN-1:0] trig_ctrl_o,
    output logic [NUM_TRIG*XLEN-1:0] trig_addr_o
);

    localparam logic [XLEN-1:0] TRIG_CNT = XLEN'(NUM_TRIG);

    typedef struct packed {
        logic [XLEN-1:0] tsel;
    } bank_t;

    bank_t bank_d, bank_q;
    csr_sel_e sel;
    logic     in_range;

    logic [XLEN-1:0] ctrl_arr [NUM_TRIG];
    logic [XLEN-1:0] cmp_arr  [NUM_TRIG];

    assign sel      = csr_sel_e'(csr_sel_i);
    assign in_range = (bank_q.tsel < TRIG_CNT);

    always_comb begin
        bank_d = bank_q;
        if (csr_we_i && sel == SEL_TSEL) bank_d.tsel = csr_wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bank_q <= '0;
        else         bank_q <= bank_d;
    end

    for (genvar i = 0; i < NUM_TRIG; i++) begin : g_slot
        logic hit;
        assign hit = in_range && (bank_q.tsel == XLEN'(i));

        dbg_trig_slot #(.XLEN(XLEN)) u_slot (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .ctrl_we_i (csr_we_i && hit && sel == SEL_CTRL),
            .cmp_we_i  (csr_we_i && hit && sel == SEL_CMP),
            .wdata_i   (csr_wdata_i),
            .ctrl_o    (ctrl_arr[i]),
            .cmp_o     (cmp_arr[i])
        );

        assign trig_ctrl_o[i*XLEN +: XLEN] = ctrl_arr[i];
        assign trig_addr_o[i*XLEN +: XLEN] = cmp_arr[i];
    end

    always_comb begin
        csr_rdata_o = '0;
        case (sel)
            SEL_TSEL: csr_rdata_o = bank_q.tsel;
            SEL_CTRL, SEL_CMP: begin
                for (int k = 0; k < NUM_TRIG; k++) begin
                    if (bank_q.tsel == XLEN'(k)) begin
                        csr_rdata_o = (sel == SEL_CTRL) ? ctrl_arr[k] : cmp_arr[k];
                    end
                end
            end
            default: csr_rdata_o = '0;
        endcase
    end

    assign avail_o = in_range && (avail_idx_i == 2'd0 || avail_idx_i == 2'd1);

    // R2
    tsel_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_we_i && csr_sel_i == 2'd0) |=> (bank_q.tsel == $past(csr_wdata_i)));

    // R4
    oor_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_we_i && !in_range && csr_sel_i != 2'd0)
        |=> ($stable(trig_ctrl_o) && $stable(trig_addr_o)));

    // R12
    third_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_we_i && csr_sel_i == 2'd3)
        |=> ($stable(trig_ctrl_o) && $stable(trig_addr_o)));

    // R5
    avail_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        avail_o |-> (bank_q.tsel < TRIG_CNT && avail_idx_i[1] == 1'b0));

endmodule

// File: tb/dbg_trig_bank_bench.sv
`timescale 1ns/1ps
module dbg_trig_bank_bench;

    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      csr_sel = 2'd0;
    logic            csr_we = 1'b0;
    logic [63:0]     csr_wdata = '0;
    logic [63:0]     csr_rdata;
    logic [1:0]      avail_idx = 2'd0;
    logic            avail;
    logic [127:0]    trig_ctrl;
    logic [127:0]    trig_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [63:0] m_tsel;
    logic [63:0] m_ctrl [2];
    logic [63:0] m_cmp  [2];

    always #4 clk = ~clk;

    dbg_trig_bank u_dbg_trig_bank (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .csr_sel_i   (csr_sel),
        .csr_we_i    (csr_we),
        .csr_wdata_i (csr_wdata),
        .csr_rdata_o (csr_rdata),
        .avail_idx_i (avail_idx),
        .avail_o     (avail),
        .trig_ctrl_o (trig_ctrl),
        .trig_addr_o (trig_addr)
    );

    localparam logic [63:0] RST_CTRL = 64'h2000_0000_0000_0000;

    function automatic logic [63:0] legal(input logic [63:0] w);
        logic [63:0] r;
        logic [3:0]  code;
        r = RST_CTRL;
        r = r | (w & 64'h5F);
        code = {w[22:21], w[17:16]};
        if (code <= 4'd3 || code == 4'd5) begin
            r[17:16] = w[17:16];
            r[22:21] = w[22:21];
        end
        return r;
    endfunction

    function automatic logic [63:0] exp_read(input logic [1:0] s);
        if (s == 2'd0) return m_tsel;
        if (s == 2'd3 || m_tsel >= 64'd2) return '0;
        return (s == 2'd1) ? m_ctrl[m_tsel[0]] : m_cmp[m_tsel[0]];
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [63:0] d);
        @(negedge clk);
        csr_sel = s; csr_wdata = d; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
        if (s == 2'd0) m_tsel = d;
        else if (s != 2'd3 && m_tsel < 64'd2) begin
            if (s == 2'd1) m_ctrl[m_tsel[0]] = legal(d);
            else           m_cmp[m_tsel[0]]  = d;
        end
    endtask

    task automatic rd(input logic [1:0] s, input string req);
        @(negedge clk);
        csr_sel = s; csr_we = 1'b0;
        #1;
        check(req, csr_rdata, exp_read(s));
    endtask

    task automatic check_exports(input string req);
        for (int k = 0; k < 2; k++) begin
            check(req, trig_ctrl[k*64 +: 64], m_ctrl[k]);
            check(req, trig_addr[k*64 +: 64], m_cmp[k]);
        end
    endtask

    task automatic check_avail(input string req);
        for (int q = 0; q < 4; q++) begin
            @(negedge clk);
            avail_idx = 2'(q);
            #1;
            check(req, {63'd0, avail}, {63'd0, (m_tsel < 64'd2) && (q < 2)});
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_tsel = '0;
        for (int k = 0; k < 2; k++) begin m_ctrl[k] = RST_CTRL; m_cmp[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, "R1");
        rd(2'd1, "R1");
        rd(2'd2, "R1");
        check_exports("R1");

        // R2 full-width selector
        wr(2'd0, 64'hDEAD_BEEF_0123_4567);
        rd(2'd0, "R2");
        // R4 out-of-range access
        rd(2'd1, "R4");
        rd(2'd2, "R4");
        wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(2'd2, 64'h1234);
        check_exports("R4");
        // R5 availability out of range
        check_avail("R5");
        wr(2'd0, 64'd2);
        check_avail("R5");

        // R6 R7 R10 all-ones write to trigger 1 (size code 15)
        wr(2'd0, 64'd1);
        check_avail("R5");
        wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(2'd1, "R6_R7_R10");
        check_exports("R3");
        // R9 code 5 (8 bytes) uses sizehi
        wr(2'd1, 64'h0000_0000_0021_0058);
        rd(2'd1, "R9_R8");
        // R10 code 4 illegal
        wr(2'd1, 64'h0000_0000_0020_0007);
        rd(2'd1, "R10");
        // R11 compare full width
        wr(2'd2, 64'h8000_0000_0000_0001);
        rd(2'd2, "R11");
        // R12 third slot
        wr(2'd3, 64'hFFFF_0000_FFFF_0000);
        rd(2'd3, "R12");
        check_exports("R12");
        // R3 trigger 0 separate from trigger 1
        wr(2'd0, 64'd0);
        check_avail("R5");
        wr(2'd1, 64'h0000_0000_0003_005F);
        wr(2'd2, 64'hCAFE);
        rd(2'd1, "R3");
        rd(2'd2, "R3");
        check_exports("R3");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            logic [63:0] d;
            op = int'($urandom_range(0, 9));
            d  = {$urandom, $urandom};
            case (op)
                0: wr(2'd0, ($urandom_range(0, 7) == 0) ? d : 64'($urandom_range(0, 2)));
                1, 2: wr(2'd1, d);
                3: wr(2'd2, d);
                4: wr(2'd3, d);
                5: rd(2'd0, "R2");
                6: rd(2'd1, "R3_R9_R10");
                7: rd(2'd2, "R11");
                8: rd(2'd3, "R12");
                default: check_exports("R3");
            endcase
        end
        check_exports("R3");

        done = 1'b1;
        finish_run();
    end

endmodule